// File: doc/BRIEF.md
# Grayscale PWM Brightness Engine

This block turns sixteen per-channel brightness words into a sixteen-bit channel-enable vector. Brightness words enter one bit at a time, most significant bit first, into a 16-bit shift register. A data-latch strobe pushes the assembled word into a chain of staging buffers. A global-latch strobe then moves the shift register content and all staged words into the active brightness registers in the same cycle. The displayed image therefore changes only at a commit and never part-way through a load.

A counter advances once for each PWM tick. The tick is a single-cycle strobe that stands for an edge of the separate PWM clock. Each channel compares the counter against its own active brightness value. Software loads the sixteen words for channels 15 down to 0 and then commits them, and the counter width can be changed between 16 and 12 bits while the block runs. Each compare result is gated by a per-channel switch bit. An optional stagger delays channel n by n ticks, so the channels do not all switch on together.

Top module: `grayscale_pwm_engine`

## Requirements
- R1: While `sdi_valid` is high, `sdi_bit` is shifted into a 16-bit register on each clock, and the first bit sent becomes bit 15 of the word.
- R2: Each `data_latch` pulse pushes the shift register word into the staging chain. After fifteen pushes, the first word of a sixteen-word load is staged for channel 15 and the fifteenth word is staged for channel 1.
- R3: A `global_latch` pulse writes the shift register word to channel 0 and writes every staged word to its channel, all in one cycle. Without that pulse, the active brightness values do not change, whatever is pushed into the chain.
- R4: Reset (synchronous, active low) clears all brightness values, the counter and the stagger chains, so `chan_on` is all zero after reset.
- R5: The counter advances by one only on a cycle with `pwm_tick` high. With `mode_12b` = 0 it runs 0 to 65535 and then wraps to 0.
- R6: With `mode_12b` = 1, the counter runs 0 to 4095 and then wraps to 0, and its upper four bits stay 0. The comparison uses only bits 11:0 of each brightness word, so bits 15:12 have no effect.
- R7: A channel's compare result is 1 while the counter is below that channel's brightness value. A value of 0 never lights the channel, and any nonzero value lights it at counter value 0, which is the state after reset before any tick.
- R8: `chan_on[i]` is 0 whenever `switch_en[i]` is 0.
- R9: With `stagger_off` = 1, every channel follows its compare result with no delay. With `stagger_off` = 0, channel n shows the compare result it had n ticks earlier, channel 0 is not delayed, and ticks that precede the reset count as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sdi_bit | input | 1 | Serial brightness data bit |
| sdi_valid | input | 1 | Shifts `sdi_bit` in this cycle |
| data_latch | input | 1 | Pushes the shift word into the staging chain |
| global_latch | input | 1 | Commits the shift word to channel 0 and the staged words to channels 1 to 15 |
| mode_12b | input | 1 | 0: 16-bit counter, 1: 12-bit counter |
| stagger_off | input | 1 | 1: channels switch together, 0: channel n delayed by n ticks |
| pwm_tick | input | 1 | One PWM clock event |
| switch_en | input | 16 | Per-channel on/off switch |
| chan_on | output | 16 | Channel enable vector |

## Verification
The hardest case to reach from the ports is the wrap of the full 16-bit counter, together with the top channel at value 65535, which stays lit for every count except the last one. The bench ticks on every clock for more than 65536 consecutive cycles and compares the whole output vector after each tick. The same sweep runs across the 4096 wrap in 12-bit mode, using words whose upper bits are set. Loading order and double buffering are exposed by giving each channel a distinct value, so each channel goes dark on a different tick, and by checking the outputs after fifteen pushes with no commit.

// File: rtl/grayscale_pwm_pkg.sv
// Shared sizing defaults for the grayscale PWM engine.
package grayscale_pwm_pkg;
    localparam int CH_N_DEF     = 16;  // number of output channels
    localparam int WORD_W_DEF   = 16;  // brightness word / wide counter width
    localparam int NARROW_W_DEF = 12;  // reduced counter width
endpackage

// File: rtl/bright_shifter.sv
// Serial-in word assembler. Shifts one bit per enabled cycle, MSB first.
// Assumes the caller sends exactly W bits per word.
module bright_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_out
);
    logic [W-1:0] sh_q;

    // shift the new bit in at the LSB end so the first bit ends at the MSB
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[W-2:0], bit_in};
    end

    assign word_out = sh_q;
endmodule

// File: rtl/bright_store.sv
// Double-buffered brightness storage: a staging chain for channels
// NCH-1..1, filled by push, and active registers written by commit.
// Assumes push and commit are never high in the same cycle.
module bright_store #(
    parameter int NCH = 16,
    parameter int W   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           commit,
    input  logic [W-1:0]   word_in,
    output logic [NCH*W-1:0] active_flat
);
    logic [W-1:0] stage_q [1:NCH-1];
    logic [W-1:0] act_q   [0:NCH-1];

    for (genvar i = 1; i < NCH; i++) begin : g_stage
        // staging entry i takes the new word (i==1) or the entry below it
        always_ff @(posedge clk) begin
            if (!rst_n)    stage_q[i] <= '0;
            else if (push) stage_q[i] <= (i == 1) ? word_in : stage_q[(i == 1) ? 1 : i-1];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_active
        // active register i loads on commit: channel 0 from the shifter
        always_ff @(posedge clk) begin
            if (!rst_n)      act_q[i] <= '0;
            else if (commit) act_q[i] <= (i == 0) ? word_in : stage_q[(i == 0) ? 1 : i];
        end
        assign active_flat[i*W +: W] = act_q[i];
    end
endmodule

// File: rtl/pwm_counter.sv
// Free-running grayscale counter advanced by a tick strobe; the wrap
// point is 2^W-1 or, in narrow mode, 2^NW-1 with the upper bits held at 0.
module pwm_counter #(
    parameter int W  = 16,
    parameter int NW = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         narrow,
    output logic [W-1:0] count
);
    localparam int HI_W = W - NW;

    logic [W-1:0]  cnt_q;
    logic [NW-1:0] low_next;
    logic [W-1:0]  cnt_next;

    // next value per mode; both wrap by natural overflow
    always_comb begin
        low_next = cnt_q[NW-1:0] + 1'b1;
        cnt_next = narrow ? {{HI_W{1'b0}}, low_next} : cnt_q + 1'b1;
    end

    // advance only on a tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_next;
    end

    assign count = cnt_q;
endmodule

// File: rtl/chan_stagger.sv
// Per-channel turn-on stagger: channel n passes through an n-deep shift
// chain clocked by the tick strobe; bypass routes raw values straight out.
module chan_stagger #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           bypass,
    input  logic [NCH-1:0] raw_in,
    output logic [NCH-1:0] dly_out
);
    logic [NCH-1:0] delayed;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == 0) begin : g_direct
            assign delayed[i] = raw_in[i];
        end else begin : g_chain
            logic [i-1:0] sr_q;
            logic [i:0]   sr_next;
            assign sr_next = {sr_q, raw_in[i]};
            // one stage per tick; oldest sample leaves at the top bit
            always_ff @(posedge clk) begin
                if (!rst_n)    sr_q <= '0;
                else if (tick) sr_q <= sr_next[i-1:0];
            end
            assign delayed[i] = sr_q[i-1];
        end
    end

    assign dly_out = bypass ? raw_in : delayed;
endmodule

// File: rtl/grayscale_pwm_engine.sv
// Top of the grayscale PWM engine: serial word loader, double-buffered
// brightness store, tick-driven counter, per-channel compare, stagger
// and switch gating. Single clock; the PWM clock arrives as pwm_tick.
module grayscale_pwm_engine
    import grayscale_pwm_pkg::*;
#(
    parameter int CH_N     = CH_N_DEF,
    parameter int WORD_W   = WORD_W_DEF,
    parameter int NARROW_W = NARROW_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi_bit,
    input  logic              sdi_valid,
    input  logic              data_latch,
    input  logic              global_latch,
    input  logic              mode_12b,
    input  logic              stagger_off,
    input  logic              pwm_tick,
    input  logic [CH_N-1:0]   switch_en,
    output logic [CH_N-1:0]   chan_on
);
    localparam int HI_W = WORD_W - NARROW_W;
    localparam logic [WORD_W-1:0] NARROW_MASK = {{HI_W{1'b0}}, {NARROW_W{1'b1}}};

    logic [WORD_W-1:0]      shift_word;
    logic [CH_N*WORD_W-1:0] bright_flat;
    logic [WORD_W-1:0]      pwm_count;
    logic [WORD_W-1:0]      cmp_mask;
    logic [CH_N-1:0]        raw_on;
    logic [CH_N-1:0]        staged_on;

    bright_shifter #(.W(WORD_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .shift_en(sdi_valid),
        .bit_in(sdi_bit), .word_out(shift_word)
    );

    bright_store #(.NCH(CH_N), .W(WORD_W)) store_i (
        .clk(clk), .rst_n(rst_n), .push(data_latch), .commit(global_latch),
        .word_in(shift_word), .active_flat(bright_flat)
    );

    pwm_counter #(.W(WORD_W), .NW(NARROW_W)) counter_i (
        .clk(clk), .rst_n(rst_n), .tick(pwm_tick),
        .narrow(mode_12b), .count(pwm_count)
    );

    // compare mask drops the upper brightness bits in narrow mode
    assign cmp_mask = mode_12b ? NARROW_MASK : '1;

    for (genvar i = 0; i < CH_N; i++) begin : g_cmp
        assign raw_on[i] = (pwm_count & cmp_mask) < (bright_flat[i*WORD_W +: WORD_W] & cmp_mask);
    end

    chan_stagger #(.NCH(CH_N)) stagger_i (
        .clk(clk), .rst_n(rst_n), .tick(pwm_tick), .bypass(stagger_off),
        .raw_in(raw_on), .dly_out(staged_on)
    );

    assign chan_on = staged_on & switch_en;
endmodule

// File: rtl/grayscale_pwm_engine_chk.sv
// Property checker for grayscale_pwm_engine, attached by bind.
module grayscale_pwm_engine_chk #(
    parameter int CH_N     = 16,
    parameter int WORD_W   = 16,
    parameter int NARROW_W = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pwm_tick,
    input logic                   mode_12b,
    input logic                   global_latch,
    input logic [WORD_W-1:0]      pwm_count,
    input logic [CH_N*WORD_W-1:0] bright_flat,
    input logic [CH_N-1:0]        chan_on
);
    // R4
    reset_dark_chk: assert property (@(posedge clk) !rst_n |=> chan_on == '0);

    // R3
    commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !global_latch |=> $stable(bright_flat));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_tick |=> $stable(pwm_count));

    // R5
    wide_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_tick && !mode_12b) |=> pwm_count == WORD_W'($past(pwm_count) + 1'b1));

    // R6
    narrow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_tick && mode_12b) |=> pwm_count[WORD_W-1:NARROW_W] == '0);
endmodule

bind grayscale_pwm_engine grayscale_pwm_engine_chk #(
    .CH_N(CH_N), .WORD_W(WORD_W), .NARROW_W(NARROW_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .mode_12b(mode_12b),
    .global_latch(global_latch), .pwm_count(pwm_count),
    .bright_flat(bright_flat), .chan_on(chan_on)
);

// File: tb/grayscale_pwm_engine_tb_top.sv
// Self-checking bench: loads brightness sets serially and sweeps the
// counter tick by tick against an arithmetic model.
module grayscale_pwm_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi_bit = 1'b0;
    logic        sdi_valid = 1'b0;
    logic        data_latch = 1'b0;
    logic        global_latch = 1'b0;
    logic        mode_12b = 1'b0;
    logic        stagger_off = 1'b1;
    logic        pwm_tick = 1'b0;
    logic [15:0] switch_en = 16'hFFFF;
    logic [15:0] chan_on;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] bw   [16];  // model of committed brightness
    logic [15:0] pend [16];  // words to load
    logic [15:0] hist [16];  // hist[k]: compare vector k+1 ticks back
    int          mcnt;

    always #2 clk = ~clk;

    grayscale_pwm_engine dut_i (
        .clk(clk), .rst_n(rst_n), .sdi_bit(sdi_bit), .sdi_valid(sdi_valid),
        .data_latch(data_latch), .global_latch(global_latch),
        .mode_12b(mode_12b), .stagger_off(stagger_off), .pwm_tick(pwm_tick),
        .switch_en(switch_en), .chan_on(chan_on)
    );

    function automatic logic [15:0] raw_vec();
        logic [15:0] r;
        logic [15:0] m;
        m = mode_12b ? 16'h0FFF : 16'hFFFF;
        for (int i = 0; i < 16; i++) r[i] = (16'(mcnt) & m) < (bw[i] & m);
        return r;
    endfunction

    function automatic logic [15:0] exp_vec();
        logic [15:0] r;
        logic [15:0] e;
        r = raw_vec();
        for (int i = 0; i < 16; i++)
            e[i] = (stagger_off || i == 0) ? r[i] : hist[i-1][i];
        return e & switch_en;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (count %0d)", tag, act, exp, mcnt);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) begin bw[i] = '0; hist[i] = '0; end
        mcnt = 0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) begin
            sdi_bit = w[b];
            sdi_valid = 1'b1;
            @(negedge clk);
        end
        sdi_valid = 1'b0;
    endtask

    // fifteen words for channels 15..1, each followed by a data latch
    task automatic push_fifteen();
        for (int c = 15; c >= 1; c--) begin
            send_word(pend[c]);
            data_latch = 1'b1;
            @(negedge clk);
            data_latch = 1'b0;
        end
    endtask

    task automatic commit_last();
        send_word(pend[0]);
        global_latch = 1'b1;
        @(negedge clk);
        global_latch = 1'b0;
        for (int i = 0; i < 16; i++) bw[i] = pend[i];
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            pwm_tick = 1'b1;
            for (int j = 15; j >= 1; j--) hist[j] = hist[j-1];
            hist[0] = raw_vec();
            mcnt = (mcnt + 1) % (mode_12b ? 4096 : 65536);
            @(negedge clk);
            check(tag, chan_on, exp_vec());
        end
        pwm_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R4: dark after reset
        do_reset();
        check("R4 reset dark", chan_on, 16'h0000);

        // R1 R2 R3 R7: distinct values per channel, load order
        for (int i = 0; i < 16; i++) pend[i] = 16'(i * 3);
        push_fifteen();
        check("R3 no commit yet", chan_on, 16'h0000);
        commit_last();
        check("R7 lit at count zero", chan_on, 16'hFFFE);
        run_ticks(60, "R1 R2 wide sweep");

        // R5: no ticks, nothing moves
        repeat (10) @(negedge clk);
        check("R5 idle hold", chan_on, exp_vec());

        // R3: pushes without commit leave the display untouched
        for (int i = 0; i < 16; i++) pend[i] = 16'(200 - i * 5);
        push_fifteen();
        check("R3 staged only", chan_on, exp_vec());
        commit_last();
        check("R3 after commit", chan_on, exp_vec());

        // R8: switch gating
        switch_en = 16'hA5C3;
        run_ticks(40, "R8 switch gating");
        switch_en = 16'hFFFF;

        // R6: 12-bit mode, upper bits set in every word
        mode_12b = 1'b1;
        do_reset();
        for (int i = 0; i < 16; i++) pend[i] = 16'hF000 | 16'(i * 250);
        push_fifteen();
        commit_last();
        check("R6 narrow start", chan_on, exp_vec());
        run_ticks(4200, "R6 narrow sweep and wrap");

        // R5: full 16-bit wrap, channel 15 at 65535
        mode_12b = 1'b0;
        do_reset();
        for (int i = 0; i < 16; i++) pend[i] = 16'(i * 4369);
        push_fifteen();
        commit_last();
        run_ticks(65600, "R5 wide sweep and wrap");

        // R9: stagger enabled, chains start empty after reset
        stagger_off = 1'b0;
        do_reset();
        for (int i = 0; i < 16; i++) pend[i] = 16'(i * 2 + 1);
        push_fifteen();
        commit_last();
        check("R9 stagger before tick", chan_on, exp_vec());
        run_ticks(60, "R9 stagger sweep");
        stagger_off = 1'b1;
        check("R9 bypass restores", chan_on, exp_vec());

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule